// File: doc/BRIEF.md
# Sensor-Driven Two-Street Traffic Controller

This block gives right-of-way to one of two crossing streets, A and B, at a time. Each street has a presence sensor that is high while cars are waiting or passing. The block is a Moore state machine with four phases. The lights depend only on the current phase, and every clock period stands for one fixed dwell interval.

The phases are:

| Phase | Street A | Street B |
|---|---|---|
| `PH_AGRN` | green | red |
| `PH_AYEL` | yellow | red |
| `PH_BGRN` | red | green |
| `PH_BYEL` | red | yellow |

The transitions are:

| Transition | Condition |
|---|---|
| `PH_AGRN` → `PH_AGRN` | while `sense_a` is high |
| `PH_AGRN` → `PH_AYEL` | when `sense_a` is low |
| `PH_AYEL` → `PH_BGRN` | always, after one cycle |
| `PH_BGRN` → `PH_BGRN` | while `sense_b` is high |
| `PH_BGRN` → `PH_BYEL` | when `sense_b` is low |
| `PH_BYEL` → `PH_AGRN` | always, after one cycle |

The parameter `ONE_HOT` selects how the phase is stored. With `ONE_HOT = 0` the phase is held in two flops using the codes `PH_AGRN` = 00, `PH_AYEL` = 01, `PH_BGRN` = 10 and `PH_BYEL` = 11. With `ONE_HOT = 1` it is held in one flop per phase. Both choices produce the same light sequence. In one-hot storage, any pattern that does not have exactly one bit set sends the machine to `PH_AGRN` on the next clock edge.

Top module: `xing_ctrl`

## Requirements
- R1: `rst` is synchronous and active high. At the first rising edge with `rst` high, the machine enters `PH_AGRN`: `light_a` = 00 (green) and `light_b` = 10 (red).
- R2: In `PH_AGRN`, if `sense_a` is high at a rising edge, the machine stays in `PH_AGRN`, whatever the value of `sense_b`.
- R3: In `PH_AGRN`, if `sense_a` is low at a rising edge, the machine moves to `PH_AYEL`: `light_a` = 01 (yellow) and `light_b` = 10.
- R4: `PH_AYEL` lasts exactly one cycle. It then moves to `PH_BGRN` (`light_a` = 10, `light_b` = 00), whatever the sensors show.
- R5: In `PH_BGRN`, if `sense_b` is high at a rising edge, the machine stays in `PH_BGRN`, whatever the value of `sense_a`.
- R6: In `PH_BGRN`, if `sense_b` is low at a rising edge, the machine moves to `PH_BYEL`: `light_a` = 10 and `light_b` = 01.
- R7: `PH_BYEL` lasts exactly one cycle. It then moves to `PH_AGRN`, whatever the sensors show.
- R8: Each light is driven only with the codes green = 00, yellow = 01 and red = 10; the code 11 never appears. At least one street shows red at all times.
- R9: Binary storage (`ONE_HOT = 0`) and one-hot storage (`ONE_HOT = 1`) produce identical light outputs, cycle for cycle, for the same inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the phase register loads on the rising edge |
| rst | input | 1 | Synchronous active-high reset to `PH_AGRN` |
| sense_a | input | 1 | Street A presence sensor, high while traffic is present |
| sense_b | input | 1 | Street B presence sensor, high while traffic is present |
| light_a | output | 2 | Street A light: 00 green, 01 yellow, 10 red |
| light_b | output | 2 | Street B light: 00 green, 01 yellow, 10 red |

## Verification
The bench drives the opposite street's sensor high during each green hold. A design that looked at the wrong sensor would then leave green early or stay there too long. It raises both sensors during each yellow phase, so a yellow phase that waited on a sensor would last more than one cycle. Reset is applied in the middle of each phase, to catch a reset that only acts in some phases or that needs an extra cycle. Both storage variants run side by side against a behavioural model, so a one-hot transition wired to the wrong bit shows up as a divergence from the binary variant and from the model.

// File: rtl/xing_pkg.sv
package xing_pkg;

    localparam int LAMP_W  = 2;
    localparam int PHASE_N = 4;
    localparam int BIN_W   = $clog2(PHASE_N);

    typedef logic [LAMP_W-1:0] lamp_t;

    localparam lamp_t LAMP_GRN = 2'b00;
    localparam lamp_t LAMP_YEL = 2'b01;
    localparam lamp_t LAMP_RED = 2'b10;

    typedef enum logic [BIN_W-1:0] {
        PH_AGRN = 2'd0,
        PH_AYEL = 2'd1,
        PH_BGRN = 2'd2,
        PH_BYEL = 2'd3
    } phase_e;

endpackage

// File: rtl/xing_core_bin.sv
module xing_core_bin
    import xing_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sense_a,
    input  logic   sense_b,
    output phase_e phase
);

    logic [BIN_W-1:0] st_q;
    logic [BIN_W-1:0] st_d;

    // Next state, written out in terms of the two state bits.
    always_comb begin
        st_d[1] = st_q[1] ^ st_q[0];
        st_d[0] = (~st_q[1] & ~st_q[0] & ~sense_a) |
                  ( st_q[1] & ~st_q[0] & ~sense_b);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= BIN_W'(PH_AGRN);
        else     st_q <= st_d;
    end

    assign phase = phase_e'(st_q);

endmodule

// File: rtl/xing_core_onehot.sv
module xing_core_onehot
    import xing_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sense_a,
    input  logic   sense_b,
    output phase_e phase
);

    localparam logic [PHASE_N-1:0] OH_AGRN = PHASE_N'(1) << PH_AGRN;
    localparam logic [PHASE_N-1:0] OH_AYEL = PHASE_N'(1) << PH_AYEL;
    localparam logic [PHASE_N-1:0] OH_BGRN = PHASE_N'(1) << PH_BGRN;
    localparam logic [PHASE_N-1:0] OH_BYEL = PHASE_N'(1) << PH_BYEL;

    logic [PHASE_N-1:0] oh_q;
    logic [PHASE_N-1:0] oh_d;

    always_comb begin
        unique case (oh_q)
            OH_AGRN: oh_d = sense_a ? OH_AGRN : OH_AYEL;
            OH_AYEL: oh_d = OH_BGRN;
            OH_BGRN: oh_d = sense_b ? OH_BGRN : OH_BYEL;
            OH_BYEL: oh_d = OH_AGRN;
            default: oh_d = OH_AGRN;   // any illegal pattern recovers to A green
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) oh_q <= OH_AGRN;
        else     oh_q <= oh_d;
    end

    always_comb begin
        unique case (oh_q)
            OH_AYEL: phase = PH_AYEL;
            OH_BGRN: phase = PH_BGRN;
            OH_BYEL: phase = PH_BYEL;
            default: phase = PH_AGRN;
        endcase
    end

endmodule

// File: rtl/xing_lamp_decode.sv
module xing_lamp_decode
    import xing_pkg::*;
(
    input  phase_e phase,
    output lamp_t  light_a,
    output lamp_t  light_b
);

    always_comb begin
        unique case (phase)
            PH_AGRN: begin light_a = LAMP_GRN; light_b = LAMP_RED; end
            PH_AYEL: begin light_a = LAMP_YEL; light_b = LAMP_RED; end
            PH_BGRN: begin light_a = LAMP_RED; light_b = LAMP_GRN; end
            PH_BYEL: begin light_a = LAMP_RED; light_b = LAMP_YEL; end
        endcase
    end

endmodule

// File: rtl/xing_ctrl.sv
module xing_ctrl
    import xing_pkg::*;
#(
    parameter bit ONE_HOT = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sense_a,
    input  logic              sense_b,
    output logic [LAMP_W-1:0] light_a,
    output logic [LAMP_W-1:0] light_b
);

    phase_e phase;

    generate
        if (ONE_HOT) begin : g_onehot
            xing_core_onehot u_core (
                .clk     (clk),
                .rst     (rst),
                .sense_a (sense_a),
                .sense_b (sense_b),
                .phase   (phase)
            );
        end else begin : g_binary
            xing_core_bin u_core (
                .clk     (clk),
                .rst     (rst),
                .sense_a (sense_a),
                .sense_b (sense_b),
                .phase   (phase)
            );
        end
    endgenerate

    xing_lamp_decode u_decode (
        .phase   (phase),
        .light_a (light_a),
        .light_b (light_b)
    );

endmodule

// File: rtl/xing_ctrl_chk.sv
module xing_ctrl_chk
    import xing_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              sense_a,
    input logic              sense_b,
    input logic [LAMP_W-1:0] light_a,
    input logic [LAMP_W-1:0] light_b
);

    a_r1_reset_to_agrn: assert property (@(posedge clk)
        rst |=> (light_a == LAMP_GRN && light_b == LAMP_RED));

    a_r2_hold_agrn: assert property (@(posedge clk) disable iff (rst)
        (light_a == LAMP_GRN && sense_a) |=> (light_a == LAMP_GRN));

    a_r3_leave_agrn: assert property (@(posedge clk) disable iff (rst)
        (light_a == LAMP_GRN && !sense_a) |=> (light_a == LAMP_YEL && light_b == LAMP_RED));

    a_r4_ayel_once: assert property (@(posedge clk) disable iff (rst)
        (light_a == LAMP_YEL) |=> (light_a == LAMP_RED && light_b == LAMP_GRN));

    a_r5_hold_bgrn: assert property (@(posedge clk) disable iff (rst)
        (light_b == LAMP_GRN && sense_b) |=> (light_b == LAMP_GRN));

    a_r6_leave_bgrn: assert property (@(posedge clk) disable iff (rst)
        (light_b == LAMP_GRN && !sense_b) |=> (light_b == LAMP_YEL && light_a == LAMP_RED));

    a_r7_byel_once: assert property (@(posedge clk) disable iff (rst)
        (light_b == LAMP_YEL) |=> (light_a == LAMP_GRN && light_b == LAMP_RED));

    a_r8_one_side_red: assert property (@(posedge clk) disable iff (rst)
        (light_a == LAMP_RED || light_b == LAMP_RED));

    a_r8_no_code11: assert property (@(posedge clk) disable iff (rst)
        (light_a != 2'b11 && light_b != 2'b11));

endmodule

bind xing_ctrl xing_ctrl_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .sense_a (sense_a),
    .sense_b (sense_b),
    .light_a (light_a),
    .light_b (light_b)
);

// File: tb/xing_ctrl_tb_top.sv
module xing_ctrl_tb_top;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 4 ns period, 250 MHz

    logic       rst = 1'b1;
    logic       sa  = 1'b0;
    logic       sb  = 1'b0;
    logic [1:0] la_b, lb_b, la_o, lb_o;

    int n_chk = 0;
    int n_err = 0;
    int model = 0;          // 0 A green, 1 A yellow, 2 B green, 3 B yellow
    bit done  = 1'b0;

    xing_ctrl #(.ONE_HOT(1'b0)) dut_i (
        .clk(clk), .rst(rst), .sense_a(sa), .sense_b(sb),
        .light_a(la_b), .light_b(lb_b));

    xing_ctrl #(.ONE_HOT(1'b1)) dut_oh_i (
        .clk(clk), .rst(rst), .sense_a(sa), .sense_b(sb),
        .light_a(la_o), .light_b(lb_o));

    function automatic logic [1:0] exp_a(int m);
        case (m)
            0:       return 2'b00;
            1:       return 2'b01;
            default: return 2'b10;
        endcase
    endfunction

    function automatic logic [1:0] exp_b(int m);
        case (m)
            2:       return 2'b00;
            3:       return 2'b01;
            default: return 2'b10;
        endcase
    endfunction

    task automatic chk(string req, string what, logic [1:0] got, logic [1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, got, exp);
        end
    endtask

    task automatic chk_safe(logic [1:0] a, logic [1:0] b, string who);
        n_chk++;
        if (a === 2'b11 || b === 2'b11 || (a !== 2'b10 && b !== 2'b10)) begin
            n_err++;
            $display("FAIL R8 %s actual=%b/%b expected one side 10, no 11", who, a, b);
        end
    endtask

    // Applies the inputs for one clock edge, then compares at the next negative edge.
    task automatic step(bit r, bit a, bit b);
        string req;
        int    nxt;
        rst = r; sa = a; sb = b;
        if (r) begin
            req = "R1"; nxt = 0;
        end else begin
            case (model)
                0:       begin req = a ? "R2" : "R3"; nxt = a ? 0 : 1; end
                1:       begin req = "R4"; nxt = 2; end
                2:       begin req = b ? "R5" : "R6"; nxt = b ? 2 : 3; end
                default: begin req = "R7"; nxt = 0; end
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        model = nxt;
        chk(req, "bin light_a", la_b, exp_a(model));
        chk(req, "bin light_b", lb_b, exp_b(model));
        chk(req, "oh light_a",  la_o, exp_a(model));
        chk(req, "oh light_b",  lb_o, exp_b(model));
        chk("R9", "oh vs bin light_a", la_o, la_b);
        chk("R9", "oh vs bin light_b", lb_o, lb_b);
        chk_safe(la_b, lb_b, "bin");
        chk_safe(la_o, lb_o, "oh");
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step(1, 0, 0);                      // R1: reset state
        step(1, 1, 1);
        step(0, 1, 0);                      // R2: hold A green, B sensor idle
        step(0, 1, 1);                      // R2: B sensor high is ignored
        step(0, 1, 1);
        step(0, 0, 1);                      // R3: leave A green
        step(0, 1, 1);                      // R4: yellow ignores both sensors
        step(0, 1, 1);                      // R5: A sensor high is ignored
        step(0, 0, 1);                      // R5
        step(0, 1, 0);                      // R6: leave B green
        step(0, 1, 1);                      // R7: yellow ignores both sensors
        step(0, 0, 0);                      // R3 directly from A green
        step(0, 0, 0);                      // R4 with sensors low
        step(0, 0, 0);                      // R6 immediately
        step(0, 0, 0);                      // R7 with sensors low
        // Reset taken from every phase.
        for (int ph = 1; ph < 4; ph++) begin
            for (int k = 0; k < 8 && model != ph; k++) step(0, 0, 0);
            step(1, 1, 1);                  // R1 from a non-initial phase
        end
        // Biased random sensors with occasional reset.
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 64) == 0, ($urandom % 4) != 0, ($urandom % 4) != 0);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule